// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block turns one request into the sequence of 16-bit bus words needed to move a group of registers between a sixteen-entry register file and memory. A 16-bit select mask chooses the registers. Entries 0 to 7 are the data registers and entries 8 to 15 are the address registers. The block works in either direction, register-to-memory (store) or memory-to-register (load). Each register moves either as its low 16 bits (word size) or as all 32 bits in two bus words (long size). The block produces every bus address itself, reads the register file for stores, and writes the register file for loads.

Two addressing variants change the walk:
- **Predecrement**: applies to stores only. The mask is walked in reverse register order with falling addresses. At the end, the addressing register is loaded with the lowest address written.
- **Postincrement**: applies to loads only. At the end, the addressing register is loaded with the address that follows the last operand.

A load always finishes with one extra read whose data is thrown away.

The bus side uses valid/ready handshaking:
- `bus_valid` is raised with a stable `bus_addr`, `bus_we` and `bus_wdata`.
- Those signals stay unchanged until the memory side returns `bus_ready`.
- A word completes in each cycle where both are high. For reads, `bus_rdata` is taken in that cycle.
- The memory may hold `bus_ready` low for any number of cycles to apply back-pressure.

Control pins stay plain. `start` is a single-cycle request and `done` is a single-cycle completion pulse.

Top module: `blkmove_seq`

## Requirements
- R1: A `start` seen while idle latches all request inputs and raises `busy` in the next cycle. A `start` seen while busy is ignored and does not change the transfer in progress.
- R2: Without predecrement, the mask is walked from bit 0 up to bit 15, and bit i selects register file entry i.
- R3: Long size moves each register as two words: bits 31:16 first, then bits 15:0 at the next address. Word size moves only bits 15:0.
- R4: Without predecrement, the first bus address is the start address, and each later word is 2 higher.
- R5: Predecrement applies only to stores; for a load it is ignored. In a predecrement store:
  - mask bit i selects entry 15-i, and mask bits are taken from bit 0 upward;
  - the first address is the start address minus 2, and each later word is 2 lower;
  - in long size, bits 15:0 are written first and bits 31:16 follow at the address 2 below.
- R6: A predecrement store writes each register's value from before the transfer, including the addressing register. Afterwards, entry 8+`areg` is loaded with the last address written; with an empty mask, that is the start address.
- R7: A load issues one extra read at the address after the last operand. Its data is written to no register.
- R8: A word-size load writes the 16-bit value sign-extended to 32 bits.
- R9: A postincrement load does not load entry 8+`areg` from memory, even when it is in the mask. Afterwards that entry is loaded with the address following the last operand.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_we` and `bus_wdata` hold their values.
- R11: An all-zero mask makes no register transfer. A load still issues its single extra read.
- R12: `done` is a one-cycle pulse, and `busy` falls after it. In the `done` cycle, `final_addr` shows the write-back address: the last address written for predecrement, otherwise the address following the last operand.
- R13: After reset, `busy`, `done`, `bus_valid` and `rf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| to_mem | input | 1 | 1 = store registers to memory, 0 = load from memory |
| is_long | input | 1 | 1 = 32-bit registers as two words, 0 = low 16 bits |
| predec | input | 1 | Predecrement walk (stores only) |
| postinc | input | 1 | Postincrement write-back (loads only) |
| areg | input | 3 | Address register used for addressing (entry 8+areg) |
| start_addr | input | ADDR_W | First address (even) |
| reg_mask | input | 16 | Register select mask |
| bus_valid | output | 1 | Bus word request valid |
| bus_ready | input | 1 | Memory accepts/completes the word |
| bus_we | output | 1 | 1 = write word, 0 = read word |
| bus_addr | output | ADDR_W | Byte address of the word |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_ready |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 32 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| final_addr | output | ADDR_W | Write-back address, valid with done |

## Verification
The hardest situation to reach is the addressing register being one of the moved registers. In a predecrement store, its original value must reach memory. In a postincrement load, the word fetched for it must be dropped in favour of the final address. This is hardest when the long-size half ordering and back-pressure arrive in the middle of a register.

The sweep therefore crosses both directions, both sizes and all three addressing variants with several kinds of mask:
- every single-bit mask, choosing `areg` so that each of bits 8 to 15 names the addressing register;
- the full and empty masks;
- pseudo-random masks.

A rotating `bus_ready` stall pattern splits long registers between their two halves. A second `start`, issued mid-transfer with a different mask, shows that the request in progress is not disturbed.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);
  localparam int AREG_W = IDX_W - 1;
  localparam int BUS_W  = 16;
  localparam int REG_W  = 2 * BUS_W;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_XFER  = 2'd1,
    S_EXTRA = 2'd2,
    S_DONE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bms_pick.sv
// Lowest-set-bit finder over the remaining select mask.
module bms_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] pos
);
  logic [N-1:0] below_any;
  logic [N-1:0] first_hot;

  assign below_any[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_below
      assign below_any[g] = below_any[g-1] | vec[g-1];
    end
    for (g = 0; g < N; g++) begin : g_hot
      assign first_hot[g] = vec[g] & ~below_any[g];
    end
  endgenerate

  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (first_hot[i]) pos = pos | IW'(i);
    end
  end
endmodule

// File: rtl/bms_addr.sv
// Bus address register: loads at request, steps by one word per completed word.
module bms_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  input  logic              down,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] final_addr
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_val;
    end else if (step_en) begin
      addr_q <= down ? addr_q - WORD_BYTES : addr_q + WORD_BYTES;
    end
  end

  assign addr = addr_q;
  // A falling walk has already stepped below the last written word.
  assign final_addr = down ? addr_q + WORD_BYTES : addr_q;
endmodule

// File: rtl/bms_data.sv
// Half selection for stores, half assembly and sign extension for loads.
module bms_data #(
  parameter int BUS_W = 16,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_high,
  input  logic             capture_hi,
  input  logic             is_long,
  input  logic [REG_W-1:0] rf_value,
  input  logic [BUS_W-1:0] rd_word,
  output logic [BUS_W-1:0] wdata,
  output logic [REG_W-1:0] wr_value
);
  logic [BUS_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (capture_hi) hi_q <= rd_word;
  end

  assign wdata    = send_high ? rf_value[REG_W-1:BUS_W] : rf_value[BUS_W-1:0];
  assign wr_value = is_long ? {hi_q, rd_word}
                            : {{(REG_W-BUS_W){rd_word[BUS_W-1]}}, rd_word};
endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
  import bms_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_mem,
  input  logic              is_long,
  input  logic              predec,
  input  logic              postinc,
  input  logic [2:0]        areg,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [15:0]       reg_mask,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  output logic [3:0]        rf_rd_idx,
  input  logic [31:0]       rf_rd_data,
  output logic              rf_wr_en,
  output logic [3:0]        rf_wr_idx,
  output logic [31:0]       rf_wr_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] final_addr
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

  seq_state_t        state_q;
  logic              dir_q, long_q, rev_q, wb_q, half_q;
  logic [AREG_W-1:0] areg_q;
  logic [NREG-1:0]   mask_q;

  logic [IDX_W-1:0]  pos;
  logic [IDX_W-1:0]  cur_reg;
  logic [NREG-1:0]   mask_rest;
  logic              start_go, ack, in_xfer, last_word, reg_done, self_hit;
  logic              req_rev;
  logic [REG_W-1:0]  load_value;
  logic [ADDR_W-1:0] addr_now;

  bms_pick #(.N(NREG), .IW(IDX_W)) u_pick (
    .vec (mask_q),
    .pos (pos)
  );

  assign req_rev   = predec & to_mem;
  assign start_go  = start & (state_q == S_IDLE);
  assign in_xfer   = (state_q == S_XFER);
  assign ack       = bus_valid & bus_ready;
  assign last_word = ~long_q | half_q;
  assign reg_done  = in_xfer & ack & last_word;
  assign cur_reg   = rev_q ? TOP_IDX - pos : pos;
  assign mask_rest = mask_q & ~(NREG'(1) << pos);
  assign self_hit  = (cur_reg == {1'b1, areg_q});

  bms_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_go),
    .load_val   (req_rev ? start_addr - ADDR_W'(2) : start_addr),
    .step_en    (in_xfer & ack),
    .down       (rev_q),
    .addr       (addr_now),
    .final_addr (final_addr)
  );

  bms_data #(.BUS_W(BUS_W), .REG_W(REG_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .send_high  (long_q & (half_q == rev_q)),
    .capture_hi (in_xfer & ack & ~dir_q & long_q & ~half_q),
    .is_long    (long_q),
    .rf_value   (rf_rd_data),
    .rd_word    (bus_rdata),
    .wdata      (bus_wdata),
    .wr_value   (load_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dir_q   <= 1'b0;
      long_q  <= 1'b0;
      rev_q   <= 1'b0;
      wb_q    <= 1'b0;
      half_q  <= 1'b0;
      areg_q  <= '0;
      mask_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start) begin
            dir_q  <= to_mem;
            long_q <= is_long;
            rev_q  <= req_rev;
            wb_q   <= to_mem ? predec : postinc;
            areg_q <= areg;
            mask_q <= reg_mask;
            half_q <= 1'b0;
            if (reg_mask != '0) state_q <= S_XFER;
            else                state_q <= to_mem ? S_DONE : S_EXTRA;
          end
        end
        S_XFER: begin
          if (ack) begin
            if (last_word) begin
              half_q <= 1'b0;
              mask_q <= mask_rest;
              if (mask_rest == '0) state_q <= dir_q ? S_DONE : S_EXTRA;
            end else begin
              half_q <= 1'b1;
            end
          end
        end
        S_EXTRA: begin
          if (ack) state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_valid = in_xfer | (state_q == S_EXTRA);
  assign bus_we    = in_xfer & dir_q;
  assign bus_addr  = addr_now;
  assign rf_rd_idx = cur_reg;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);

  always_comb begin
    rf_wr_en   = 1'b0;
    rf_wr_idx  = cur_reg;
    rf_wr_data = load_value;
    if (done && wb_q) begin
      rf_wr_en   = 1'b1;
      rf_wr_idx  = {1'b1, areg_q};
      rf_wr_data = REG_W'(final_addr);
    end else if (reg_done && !dir_q && !(wb_q && self_hit)) begin
      rf_wr_en = 1'b1;
    end
  end
endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              rf_wr_en
);
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));

  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && bus_we |=> $stable(bus_wdata));

  a_r10_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> busy);

  a_r7_no_rf_write_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en && bus_valid |-> !bus_we);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r12_done_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid);
endmodule

bind blkmove_seq bms_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rf_wr_en  (rf_wr_en)
);

// File: tb/blkmove_seq_bench.sv
module blkmove_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, to_mem = 1'b0, is_long = 1'b0;
  logic          predec = 1'b0, postinc = 1'b0;
  logic [2:0]    areg = '0;
  logic [AW-1:0] start_addr = '0;
  logic [15:0]   reg_mask = '0;
  logic          bus_valid, bus_we, bus_ready = 1'b0;
  logic [AW-1:0] bus_addr, final_addr;
  logic [15:0]   bus_wdata, bus_rdata;
  logic [3:0]    rf_rd_idx, rf_wr_idx;
  logic [31:0]   rf_rd_data, rf_wr_data;
  logic          rf_wr_en, busy, done;

  logic [15:0] mem [0:1023];
  logic [31:0] rf  [0:15];
  logic [31:0] exp_rf [0:15];
  logic [31:0] e_addr [0:63];
  logic        e_we   [0:63];
  logic [15:0] e_data [0:63];
  int          e_n;
  logic [31:0] exp_final;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdata  = mem[bus_addr[10:1]];
  assign rf_rd_data = rf[rf_rd_idx];

  blkmove_seq #(.ADDR_W(AW)) u_blkmove_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem), .is_long(is_long),
    .predec(predec), .postinc(postinc), .areg(areg), .start_addr(start_addr),
    .reg_mask(reg_mask), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .busy(busy), .done(done),
    .final_addr(final_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic push(input logic [31:0] a, input logic w, input logic [15:0] d);
    e_addr[e_n] = a; e_we[e_n] = w; e_data[e_n] = d; e_n++;
  endtask

  // Expected bus sequence and register file contents, from the requirements.
  task automatic build_exp(input bit tm, input bit lng, input bit pre, input bit post,
                           input logic [2:0] ar, input logic [31:0] base,
                           input logic [15:0] mask);
    logic [31:0] a, v;
    e_n = 0;
    for (int r = 0; r < 16; r++) exp_rf[r] = rf[r];
    if (pre && tm) begin
      // R5 / R6: reverse order, falling addresses, original values
      a = base - 32'd2;
      for (int i = 0; i < 16; i++) begin
        if (mask[i]) begin
          v = rf[15 - i];
          push(a, 1'b1, v[15:0]); a = a - 32'd2;
          if (lng) begin push(a, 1'b1, v[31:16]); a = a - 32'd2; end
        end
      end
      exp_final = a + 32'd2;
      exp_rf[8 + ar] = exp_final;
    end else begin
      // R2 / R3 / R4: ascending order, rising addresses
      a = base;
      for (int r = 0; r < 16; r++) begin
        if (mask[r]) begin
          if (tm) begin
            v = rf[r];
            if (lng) begin
              push(a, 1'b1, v[31:16]); push(a + 32'd2, 1'b1, v[15:0]); a = a + 32'd4;
            end else begin
              push(a, 1'b1, v[15:0]); a = a + 32'd2;
            end
          end else begin
            if (lng) begin
              v = {mem[a[10:1]], mem[(a + 32'd2) >> 1]};
              push(a, 1'b0, 16'h0); push(a + 32'd2, 1'b0, 16'h0); a = a + 32'd4;
            end else begin
              v = {{16{mem[a[10:1]][15]}}, mem[a[10:1]]};   // R8 sign extension
              push(a, 1'b0, 16'h0); a = a + 32'd2;
            end
            if (!(post && r == 8 + ar)) exp_rf[r] = v;          // R9 ignore
          end
        end
      end
      exp_final = a;
      if (!tm) begin
        push(a, 1'b0, 16'h0);                                 // R7 extra read
        if (post) exp_rf[8 + ar] = a;                         // R9 write-back
      end
    end
  endtask

  task automatic run_case(input int cs, input bit tm, input bit lng, input int mode,
                          input logic [2:0] ar, input logic [31:0] base,
                          input logic [15:0] mask);
    int  got_n = 0;
    bit  done_seen = 1'b0;
    bit  ended = 1'b0;
    bit  pre = (mode == 1);
    bit  post = (mode == 2);
    int  bad_rf;
    string tg;
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503 + cs * 977) ^ 16'h8421;
    for (int r = 0; r < 16; r++)
      rf[r] = {16'(r * 4099 + cs * 31) ^ 16'h9000, 16'(r * 7919 + cs * 13)};
    build_exp(tm, lng, pre, post, ar, base, mask);

    @(negedge clk);
    to_mem = tm; is_long = lng; predec = pre; postinc = post; areg = ar;
    start_addr = base; reg_mask = mask; start = 1'b1;
    for (int it = 0; it < 400 && !ended; it++) begin
      @(negedge clk);
      // R1: a second request mid-transfer, with a different mask, is ignored
      start = (it == 3) && !done && !done_seen;
      if (it == 3) reg_mask = ~mask;
      bus_ready = bus_valid && (((it + cs) % 3) != 0);
      #1;
      if (it == 0) check(busy == 1'b1, "R1", "busy after start", 32'(busy), 32'd1);
      if (done_seen) begin
        check(!done && !busy, "R12", "done pulse length / busy fall",
              {30'd0, done, busy}, 32'd0);
        ended = 1'b1;
      end else begin
        if (bus_valid && bus_ready) begin
          // R10: one word per cycle where valid and ready meet
          if (got_n < e_n) begin
            tg = (pre && tm) ? "R5" : (!tm && got_n == e_n - 1) ? "R7" :
                 lng ? "R3" : tm ? "R4" : "R2";
            check(bus_addr == e_addr[got_n] && bus_we == e_we[got_n], tg,
                  "bus address/direction", bus_addr, e_addr[got_n]);
            if (e_we[got_n])
              check(bus_wdata == e_data[got_n], (pre && tm) ? "R6" : "R3",
                    "bus write data", 32'(bus_wdata), 32'(e_data[got_n]));
          end
          if (bus_we) mem[bus_addr[10:1]] = bus_wdata;
          got_n++;
        end
        if (rf_wr_en) rf[rf_wr_idx] = rf_wr_data;
        if (done) begin
          done_seen = 1'b1;
          check(final_addr == exp_final, "R12", "final address", final_addr, exp_final);
        end
      end
    end
    bus_ready = 1'b0;
    start = 1'b0;
    check(ended, "R12", "completion within limit", 32'(ended), 32'd1);
    check(got_n == e_n, (mask == 16'h0) ? "R11" : "R7", "bus word count",
          32'(got_n), 32'(e_n));
    bad_rf = -1;
    for (int r = 15; r >= 0; r--) if (rf[r] !== exp_rf[r]) bad_rf = r;
    tg = tm ? "R6" : post ? "R9" : lng ? "R3" : "R8";
    if (bad_rf >= 0)
      check(1'b0, tg, $sformatf("register %0d", bad_rf), rf[bad_rf], exp_rf[bad_rf]);
    else
      check(1'b1, tg, "register file", 32'd0, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R12 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int cs = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] m;
    logic [2:0]  ar;
    repeat (3) @(negedge clk);
    // R13: reset state
    check(!busy && !done && !bus_valid && !rf_wr_en, "R13", "reset outputs",
          {28'd0, busy, done, bus_valid, rf_wr_en}, 32'd0);
    rst_n = 1'b1;
    for (int tm = 0; tm < 2; tm++)
      for (int lng = 0; lng < 2; lng++)
        for (int mode = 0; mode < 3; mode++)
          for (int k = 0; k < 28; k++) begin
            ar = 3'(cs % 8);
            if (k == 0)       m = 16'h0000;      // R11
            else if (k == 1)  m = 16'hFFFF;
            else if (k < 18) begin
              m = 16'h1 << (k - 2);
              if (k - 2 >= 8) ar = 3'(k - 10);   // addressing register in mask
            end else begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              m = lfsr;
            end
            run_case(cs, tm[0], lng[0], mode, ar, 32'h400 + 32'((cs * 6) & 'h7e), m);
            cs++;
          end
    finish_run();
  end
endmodule